// File: doc/BRIEF.md
# Debug System Bus Access Engine

This block lets a debugger reach system memory without stopping a processor. The debugger works through a small register window. It sets an access size and some mode bits in a control word, loads up to four 32-bit address words, and reads or writes four 32-bit data words. Certain register accesses start bus transfers as a side effect. Writing the lowest address word can start a read. Writing the lowest data word starts a write. Reading the lowest data word can advance the address and fetch the next item. This allows a block of memory to be streamed with one register access per item.

Transfers leave on a request/response memory port. The request carries an address, a size code and 64 bits of write data. The response returns read data and a fault flag. A controller with three states runs each transfer. `SB_IDLE` moves to `SB_RD_WAIT` on a read trigger and to `SB_WR_WAIT` on a write trigger. Each wait state returns to `SB_IDLE` in the cycle a response arrives. Only one transfer is outstanding at a time. A sticky error field records an unsupported size or a bus fault, and blocks further triggers until software clears it.

Top module: `dbg_sba_engine`

## Requirements
- R1: After reset all address words, data words, mode bits, the size code and both error indications are zero. The control word reads version 1 in bits [31:28] and capability bits {64,32,16,8} in bits [19:16]; with the default 64-bit maximum it reads 0x100F0000.
- R2: The size code in control bits [6:4] selects 8<<code bits. A trigger whose code exceeds the configured maximum width issues no bus request and sets the error field (bits [10:8]) to 3.
- R3: A response with the fault flag sets the error field to 2, and read data from that transfer is discarded.
- R4: Writing the control word clears each error-field bit written with one and keeps each bit written with zero. While the field is nonzero, no trigger starts a transfer.
- R5: With autoincrement (control bit 2) set, the address advances by 1<<code bytes. A carry out of address word 0 ripples into words 1, 2 and 3.
- R6: A bus request stays asserted, with stable address, size and direction, until its response arrives.
- R7: Writing address word 0 (register 1) while the error field is zero and read-on-address (control bit 0) is set starts a bus read at the new address.
- R8: Reading data word 0 (register 5) while the error field is zero returns the data held before the read. It then advances the address if autoincrement is set, and starts a read at the advanced address if read-on-data (control bit 1) is set.
- R9: Writing data word 0 while the error field is zero starts a bus write. The address advances only after that write completes without a fault.
- R10: A 64-bit access carries data word 0 in bits [31:0] and data word 1 in bits [63:32]. Narrower reads zero-extend into data word 0 and leave data word 1 unchanged.
- R11: While a transfer is outstanding, control bit 12 reads one. Writes to address or data words and reads of data word 0 have no side effect during that time and set busy-error (control bit 13), which is cleared by writing one to it. Mode and size fields are held during that time.
- R12: Register map: 0 is control, 1 to 4 are address words 0 to 3, 5 to 8 are data words 0 to 3, and other registers read zero. Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | REG_AW | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Register read data, valid one cycle after reg_re |
| bus_req | output | 1 | Bus request, held until response |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | BUS_ADDR_W | Request address |
| bus_size | output | 3 | Size code of the request |
| bus_wdata | output | 64 | Write data |
| bus_rsp_valid | input | 1 | Response strobe |
| bus_rdata | input | 64 | Response read data |
| bus_rsp_err | input | 1 | Response fault flag |

## Verification
On every cycle, the assertions check that requests stay stable until answered (R6) and that no request carries an unsupported size (R2). They also check that a nonzero error field changes only through a control write (R4), that a request begins only when the error field was clear, and that a side-effect access made while busy raises busy-error (R11). The bench scenarios show what depends on data and ordering: address carry across words, the old-data-then-fetch order of a data read, placement of 64-bit and narrow data, and fault data being discarded. They also show that accesses dropped while busy leave no trace in the registers.

// File: rtl/dbg_sba_pkg.sv
`timescale 1ns/1ps
package dbg_sba_pkg;

    typedef enum logic [1:0] {
        SB_IDLE    = 2'd0,
        SB_RD_WAIT = 2'd1,
        SB_WR_WAIT = 2'd2
    } sb_state_e;

    // control word field positions
    localparam int CF_RD_ON_ADDR = 0;
    localparam int CF_RD_ON_DATA = 1;
    localparam int CF_AUTOINC    = 2;
    localparam int CF_SIZE_LO    = 4;
    localparam int CF_ERR_LO     = 8;
    localparam int CF_BUSY       = 12;
    localparam int CF_BUSY_ERR   = 13;
    localparam int CF_CAP_LO     = 16;
    localparam int CF_VER_LO     = 28;

    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_FAULT = 3'd2;
    localparam logic [2:0] ERR_SIZE  = 3'd3;

endpackage

// File: rtl/dbg_sba_addr_word.sv
`timescale 1ns/1ps
module dbg_sba_addr_word (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_val,
    input  logic        inc,
    input  logic [31:0] addend,
    output logic [31:0] word_q,
    output logic        carry_o
);

    logic [32:0] sum;

    always_comb begin
        sum     = {1'b0, word_q} + {1'b0, addend};
        carry_o = sum[32];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= load_val;
        end else if (inc) begin
            word_q <= sum[31:0];
        end
    end

endmodule

// File: rtl/dbg_sba_fsm.sv
`timescale 1ns/1ps
module dbg_sba_fsm
    import dbg_sba_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_rd,
    input  logic start_wr,
    input  logic rsp_valid,
    input  logic rsp_err,
    output logic busy,
    output logic req,
    output logic req_we,
    output logic rd_done,
    output logic wr_done,
    output logic fault
);

    sb_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SB_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SB_IDLE: begin
                if (start_rd) begin
                    st_d = SB_RD_WAIT;
                end else if (start_wr) begin
                    st_d = SB_WR_WAIT;
                end
            end
            SB_RD_WAIT: if (rsp_valid) st_d = SB_IDLE;
            SB_WR_WAIT: if (rsp_valid) st_d = SB_IDLE;
            default:    st_d = SB_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        req     = 1'b0;
        req_we  = 1'b0;
        rd_done = 1'b0;
        wr_done = 1'b0;
        fault   = 1'b0;
        unique case (st_q)
            SB_IDLE: begin
            end
            SB_RD_WAIT: begin
                busy    = 1'b1;
                req     = 1'b1;
                rd_done = rsp_valid && !rsp_err;
                fault   = rsp_valid && rsp_err;
            end
            SB_WR_WAIT: begin
                busy    = 1'b1;
                req     = 1'b1;
                req_we  = 1'b1;
                wr_done = rsp_valid && !rsp_err;
                fault   = rsp_valid && rsp_err;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dbg_sba_engine.sv
`timescale 1ns/1ps
module dbg_sba_engine
    import dbg_sba_pkg::*;
#(
    parameter int MAX_BUS_BITS = 64,
    parameter int BUS_ADDR_W   = 64,
    parameter int ADDR_WORDS   = 4,
    parameter int DATA_WORDS   = 4,
    parameter int REG_AW       = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    input  logic                  reg_we,
    input  logic                  reg_re,
    output logic [31:0]           reg_rdata,
    output logic                  bus_req,
    output logic                  bus_we,
    output logic [BUS_ADDR_W-1:0] bus_addr,
    output logic [2:0]            bus_size,
    output logic [63:0]           bus_wdata,
    input  logic                  bus_rsp_valid,
    input  logic [63:0]           bus_rdata,
    input  logic                  bus_rsp_err
);

    localparam int  HAS_BUS   = (MAX_BUS_BITS >= 8) ? 1 : 0;
    localparam int  MAX_CODE  = (MAX_BUS_BITS >= 64) ? 3 :
                                (MAX_BUS_BITS >= 32) ? 2 :
                                (MAX_BUS_BITS >= 16) ? 1 : 0;
    localparam int  ADDR_BITS = 32 * ADDR_WORDS;
    localparam int  ADDR_BASE = 1;
    localparam int  DATA_BASE = ADDR_BASE + ADDR_WORDS;
    localparam logic [3:0] CAPS = {(MAX_BUS_BITS >= 64), (MAX_BUS_BITS >= 32),
                                   (MAX_BUS_BITS >= 16), (MAX_BUS_BITS >= 8)};
    localparam logic [3:0] VERSION = (HAS_BUS != 0) ? 4'd1 : 4'd0;

    // ---------------- mode and status state
    logic        rd_on_addr_q, rd_on_data_q, autoinc_q;
    logic [2:0]  size_q;
    logic [2:0]  err_q, err_d;
    logic        busy_err_q;
    logic [DATA_WORDS-1:0][31:0] data_q;
    logic [ADDR_WORDS-1:0][31:0] addr_w;
    logic [ADDR_BITS-1:0]        addr_flat;

    // ---------------- decode
    logic                  ctrl_wr;
    logic [ADDR_WORDS-1:0] addr_sel_wr;
    logic [DATA_WORDS-1:0] data_sel_wr;
    logic                  data0_rd;
    logic                  any_word_wr;

    always_comb begin
        ctrl_wr  = reg_we && (reg_addr == REG_AW'(0));
        data0_rd = reg_re && (reg_addr == REG_AW'(DATA_BASE));
        for (int i = 0; i < ADDR_WORDS; i++) begin
            addr_sel_wr[i] = reg_we && (reg_addr == REG_AW'(ADDR_BASE + i));
        end
        for (int i = 0; i < DATA_WORDS; i++) begin
            data_sel_wr[i] = reg_we && (reg_addr == REG_AW'(DATA_BASE + i));
        end
        any_word_wr = (|addr_sel_wr) || (|data_sel_wr);
    end

    // ---------------- transfer controller
    logic busy, fsm_req, fsm_we, rd_done, wr_done, bus_fault;
    logic start_rd, start_wr;

    dbg_sba_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .rsp_valid (bus_rsp_valid),
        .rsp_err   (bus_rsp_err),
        .busy      (busy),
        .req       (fsm_req),
        .req_we    (fsm_we),
        .rd_done   (rd_done),
        .wr_done   (wr_done),
        .fault     (bus_fault)
    );

    // ---------------- trigger qualification
    logic size_ok, trig_rd_addr, trig_rd_data, trig_wr, need_size, size_fault;
    logic inc_en, busy_hit;

    always_comb begin
        size_ok      = (HAS_BUS != 0) && (int'(size_q) <= MAX_CODE);
        trig_rd_addr = addr_sel_wr[0] && !busy && rd_on_addr_q && (err_q == ERR_NONE);
        trig_rd_data = data0_rd && !busy && (err_q == ERR_NONE);
        trig_wr      = data_sel_wr[0] && !busy && (err_q == ERR_NONE);
        need_size    = trig_rd_addr || trig_wr ||
                       (trig_rd_data && (autoinc_q || rd_on_data_q));
        size_fault   = need_size && !size_ok;
        start_rd     = size_ok && (trig_rd_addr || (trig_rd_data && rd_on_data_q));
        start_wr     = size_ok && trig_wr;
        inc_en       = autoinc_q && ((size_ok && trig_rd_data) || wr_done);
        busy_hit     = busy && (any_word_wr || data0_rd);
    end

    // ---------------- address words with rippling carry
    logic [ADDR_WORDS:0] carry;
    logic [31:0]         step_bytes;

    assign step_bytes = 32'd1 << size_q[1:0];
    assign carry[0]   = 1'b0;

    generate
        for (genvar gi = 0; gi < ADDR_WORDS; gi++) begin : g_addr
            logic [31:0] addend;
            if (gi == 0) begin : g_lsw
                assign addend = step_bytes;
            end else begin : g_upper
                assign addend = {31'd0, carry[gi]};
            end
            dbg_sba_addr_word u_word (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (addr_sel_wr[gi] && !busy),
                .load_val (reg_wdata),
                .inc      (inc_en),
                .addend   (addend),
                .word_q   (addr_w[gi]),
                .carry_o  (carry[gi+1])
            );
        end
    endgenerate

    assign addr_flat = addr_w;

    // ---------------- error field next value
    always_comb begin
        err_d = err_q;
        if (ctrl_wr) begin
            err_d = err_q & ~reg_wdata[CF_ERR_LO +: 3];
        end
        if (size_fault) begin
            err_d = ERR_SIZE;
        end
        if (bus_fault) begin
            err_d = ERR_FAULT;
        end
    end

    // ---------------- control state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_on_addr_q <= 1'b0;
            rd_on_data_q <= 1'b0;
            autoinc_q    <= 1'b0;
            size_q       <= '0;
            err_q        <= ERR_NONE;
            busy_err_q   <= 1'b0;
        end else begin
            err_q <= err_d;
            if (ctrl_wr && !busy) begin
                rd_on_addr_q <= reg_wdata[CF_RD_ON_ADDR];
                rd_on_data_q <= reg_wdata[CF_RD_ON_DATA];
                autoinc_q    <= reg_wdata[CF_AUTOINC];
                size_q       <= reg_wdata[CF_SIZE_LO +: 3];
            end
            if (busy_hit) begin
                busy_err_q <= 1'b1;
            end else if (ctrl_wr && reg_wdata[CF_BUSY_ERR]) begin
                busy_err_q <= 1'b0;
            end
        end
    end

    // ---------------- data words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            for (int i = 0; i < DATA_WORDS; i++) begin
                if (data_sel_wr[i] && !busy) begin
                    data_q[i] <= reg_wdata;
                end
            end
            if (rd_done) begin
                unique case (size_q[1:0])
                    2'd0: data_q[0] <= {24'd0, bus_rdata[7:0]};
                    2'd1: data_q[0] <= {16'd0, bus_rdata[15:0]};
                    2'd2: data_q[0] <= bus_rdata[31:0];
                    2'd3: begin
                        data_q[0] <= bus_rdata[31:0];
                        data_q[1] <= bus_rdata[63:32];
                    end
                    default: data_q[0] <= bus_rdata[31:0];
                endcase
            end
        end
    end

    // ---------------- register read port
    logic [31:0] ctrl_word, rd_mux;

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CF_RD_ON_ADDR]    = rd_on_addr_q;
        ctrl_word[CF_RD_ON_DATA]    = rd_on_data_q;
        ctrl_word[CF_AUTOINC]       = autoinc_q;
        ctrl_word[CF_SIZE_LO +: 3]  = size_q;
        ctrl_word[CF_ERR_LO +: 3]   = err_q;
        ctrl_word[CF_BUSY]          = busy;
        ctrl_word[CF_BUSY_ERR]      = busy_err_q;
        ctrl_word[CF_CAP_LO +: 4]   = CAPS;
        ctrl_word[CF_VER_LO +: 4]   = VERSION;
    end

    always_comb begin
        rd_mux = '0;
        if (reg_addr == REG_AW'(0)) begin
            rd_mux = ctrl_word;
        end
        for (int i = 0; i < ADDR_WORDS; i++) begin
            if (reg_addr == REG_AW'(ADDR_BASE + i)) rd_mux = addr_w[i];
        end
        for (int i = 0; i < DATA_WORDS; i++) begin
            if (reg_addr == REG_AW'(DATA_BASE + i)) rd_mux = data_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_re) begin
            reg_rdata <= rd_mux;
        end
    end

    // ---------------- bus port
    assign bus_req   = fsm_req;
    assign bus_we    = fsm_we;
    assign bus_addr  = addr_flat[BUS_ADDR_W-1:0];
    assign bus_size  = size_q;
    assign bus_wdata = {data_q[1], data_q[0]};

endmodule

// File: rtl/dbg_sba_checker.sv
`timescale 1ns/1ps
module dbg_sba_checker #(
    parameter int BUS_ADDR_W = 64,
    parameter int MAX_CODE   = 3,
    parameter int REG_AW     = 4,
    parameter int WORD_LO    = 1,
    parameter int WORD_HI    = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_req,
    input logic                  bus_we,
    input logic [BUS_ADDR_W-1:0] bus_addr,
    input logic [2:0]            bus_size,
    input logic                  bus_rsp_valid,
    input logic                  reg_we,
    input logic                  reg_re,
    input logic [REG_AW-1:0]     reg_addr,
    input logic [2:0]            err_q,
    input logic                  busy_err_q,
    input logic                  busy
);

    logic word_wr, data0_rd;
    assign word_wr  = reg_we && (reg_addr >= REG_AW'(WORD_LO)) && (reg_addr <= REG_AW'(WORD_HI));
    assign data0_rd = reg_re && (reg_addr == REG_AW'(WORD_HI - 3));

    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_rsp_valid) |=> (bus_req && $stable(bus_addr) &&
                                         $stable(bus_we) && $stable(bus_size)));

    a_r2_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (int'(bus_size) <= MAX_CODE));

    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_q != 3'd0) && !(reg_we && (reg_addr == REG_AW'(0)))) |=> (err_q == $past(err_q)));

    a_r4_no_start_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> ($past(err_q) == 3'd0));

    a_r11_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (word_wr || data0_rd)) |=> busy_err_q);

endmodule

bind dbg_sba_engine dbg_sba_checker #(
    .BUS_ADDR_W (BUS_ADDR_W),
    .MAX_CODE   (MAX_CODE),
    .REG_AW     (REG_AW),
    .WORD_LO    (ADDR_BASE),
    .WORD_HI    (DATA_BASE + DATA_WORDS - 1)
) u_sba_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_size      (bus_size),
    .bus_rsp_valid (bus_rsp_valid),
    .reg_we        (reg_we),
    .reg_re        (reg_re),
    .reg_addr      (reg_addr),
    .err_q         (err_q),
    .busy_err_q    (busy_err_q),
    .busy          (busy)
);

// File: tb/test_dbg_sba_engine.sv
`timescale 1ns/1ps
module test_dbg_sba_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [31:0] reg_rdata;
    logic        bus_req, bus_we;
    logic [63:0] bus_addr;
    logic [2:0]  bus_size;
    logic [63:0] bus_wdata;
    logic        bus_rsp_valid = 1'b0;
    logic [63:0] bus_rdata = '0;
    logic        bus_rsp_err = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // responder state
    int          lat = 2;
    int          cnt = 0;
    int          wr_count = 0;
    int          rd_count = 0;
    logic [63:0] last_wr_addr = '0;
    logic [63:0] last_wr_data = '0;
    logic [2:0]  last_wr_size = '0;
    logic [63:0] last_rd_addr = '0;

    always #10 clk = ~clk;

    dbg_sba_engine i_dbg_sba_engine (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rsp_valid(bus_rsp_valid), .bus_rdata(bus_rdata),
        .bus_rsp_err(bus_rsp_err)
    );

    function automatic logic [31:0] mem_lo(input logic [63:0] a);
        return a[31:0] ^ 32'h5A5A5A5A;
    endfunction
    function automatic logic [31:0] mem_hi(input logic [63:0] a);
        return a[31:0] + 32'h10000000;
    endfunction

    // memory responder: faults on addresses whose bits [31:16] are 16'hDEAD
    always @(posedge clk) begin
        if (bus_req && !bus_rsp_valid) begin
            if (cnt >= lat) begin
                cnt           <= 0;
                bus_rsp_valid <= 1'b1;
                bus_rsp_err   <= (bus_addr[31:16] == 16'hDEAD);
                bus_rdata     <= {mem_hi(bus_addr), mem_lo(bus_addr)};
                if (bus_we) begin
                    wr_count     <= wr_count + 1;
                    last_wr_addr <= bus_addr;
                    last_wr_data <= bus_wdata;
                    last_wr_size <= bus_size;
                end else begin
                    rd_count     <= rd_count + 1;
                    last_rd_addr <= bus_addr;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            bus_rsp_valid <= 1'b0;
            bus_rsp_err   <= 1'b0;
        end
    end

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            report();
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a); reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a); reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    localparam logic [31:0] CONST = 32'h100F0000;

    task automatic t_reset();
        logic [31:0] v;
        rd(0, v); chk("R1 ctrl after reset", 64'(v), 64'(CONST));
        rd(1, v); chk("R1 addr0 after reset", 64'(v), 64'd0);
        rd(6, v); chk("R1 data1 after reset", 64'(v), 64'd0);
        rd(9, v); chk("R12 unmapped reads zero", 64'(v), 64'd0);
    endtask

    task automatic t_write_basic();
        logic [31:0] v;
        int n0;
        n0 = wr_count;
        wr(0, 32'h20);
        wr(1, 32'h100);
        wr(5, 32'hDEADBEEF);
        settle();
        chk("R9 write issued", 64'(wr_count - n0), 64'd1);
        chk("R9 write addr", last_wr_addr, 64'h100);
        chk("R10 write low data", last_wr_data & 64'hFFFFFFFF, 64'hDEADBEEF);
        chk("R2 write size", 64'(last_wr_size), 64'd2);
        rd(1, v); chk("R9 no inc without autoinc", 64'(v), 64'h100);
    endtask

    task automatic t_autoinc_write();
        logic [31:0] v;
        wr(0, 32'h24);
        wr(5, 32'h1); settle();
        wr(5, 32'h2); settle();
        chk("R5 second write at advanced addr", last_wr_addr, 64'h104);
        rd(1, v); chk("R5 addr after two writes", 64'(v), 64'h108);
    endtask

    task automatic t_carry();
        logic [31:0] v;
        wr(0, 32'h24);
        wr(1, 32'hFFFFFFFC);
        wr(2, 32'hFFFFFFFF);
        wr(3, 32'h5);
        wr(5, 32'h77); settle();
        chk("R5 write addr before carry", last_wr_addr, 64'hFFFFFFFF_FFFFFFFC);
        rd(1, v); chk("R5 carry word0", 64'(v), 64'h0);
        rd(2, v); chk("R5 carry word1", 64'(v), 64'h0);
        rd(3, v); chk("R5 carry word2", 64'(v), 64'h6);
        wr(3, 32'h0);
    endtask

    task automatic t_read_on_addr();
        logic [31:0] v;
        wr(0, 32'h21);
        wr(1, 32'h200); settle();
        chk("R7 read addr", last_rd_addr, 64'h200);
        rd(5, v); chk("R7 data0 from read", 64'(v), 64'(mem_lo(64'h200)));
    endtask

    task automatic t_read_on_data();
        logic [31:0] v;
        wr(0, 32'h20);
        wr(1, 32'h300);
        wr(5, 32'h12345678); settle();
        wr(0, 32'h26);
        rd(5, v); chk("R8 first read returns old data", 64'(v), 64'h12345678);
        settle();
        chk("R8 fetch at advanced addr", last_rd_addr, 64'h304);
        rd(5, v); chk("R8 second read returns fetched", 64'(v), 64'(mem_lo(64'h304)));
        settle();
        chk("R8 next fetch addr", last_rd_addr, 64'h308);
        rd(1, v); chk("R8 addr after two reads", 64'(v), 64'h308);
    endtask

    task automatic t_64bit();
        logic [31:0] v;
        wr(0, 32'h30);
        wr(1, 32'h500);
        wr(6, 32'hCAFEF00D);
        wr(5, 32'h11223344); settle();
        chk("R10 64-bit write data", last_wr_data, 64'hCAFEF00D_11223344);
        chk("R2 64-bit size", 64'(last_wr_size), 64'd3);
        wr(0, 32'h31);
        wr(1, 32'h600); settle();
        rd(5, v); chk("R10 64-bit read low", 64'(v), 64'(mem_lo(64'h600)));
        rd(6, v); chk("R10 64-bit read high", 64'(v), 64'(mem_hi(64'h600)));
        wr(0, 32'h01);
        wr(1, 32'h7AB); settle();
        rd(5, v); chk("R10 byte read zero-extended", 64'(v), 64'(mem_lo(64'h7AB) & 32'hFF));
        rd(6, v); chk("R10 byte read keeps data1", 64'(v), 64'(mem_hi(64'h600)));
    endtask

    task automatic t_size_err();
        logic [31:0] v;
        int n0;
        n0 = wr_count;
        wr(0, 32'h40);
        wr(5, 32'hAA); settle();
        chk("R2 no bus write for bad size", 64'(wr_count - n0), 64'd0);
        rd(0, v); chk("R2 error field 3", 64'(v), 64'(CONST | 32'h340));
        wr(0, 32'h20);
        rd(0, v); chk("R4 zero write keeps error", 64'(v), 64'(CONST | 32'h320));
        wr(5, 32'hBB); settle();
        chk("R4 no write while error set", 64'(wr_count - n0), 64'd0);
        wr(0, 32'h120);
        rd(0, v); chk("R4 clear one bit", 64'(v), 64'(CONST | 32'h220));
        wr(0, 32'h200);
        rd(0, v); chk("R4 clear remaining bit", 64'(v), 64'(CONST));
    endtask

    task automatic t_fault();
        logic [31:0] v0, v;
        wr(0, 32'h21);
        rd(5, v0);
        wr(1, 32'hDEAD0000); settle();
        rd(0, v); chk("R3 fault sets error 2", 64'(v), 64'(CONST | 32'h221));
        rd(5, v); chk("R3 fault data discarded", 64'(v), 64'(v0));
        wr(1, 32'h400); settle();
        chk("R7 no read while error set", last_rd_addr, 64'hDEAD0000);
        wr(0, 32'h200);
        rd(0, v); chk("R4 error cleared", 64'(v), 64'(CONST));
    endtask

    task automatic t_busy();
        logic [31:0] v;
        int n0;
        lat = 20;
        wr(0, 32'h20);
        wr(1, 32'h800);
        n0 = wr_count;
        wr(5, 32'h1);
        rd(0, v); chk("R11 busy bit", 64'(v), 64'(CONST | 32'h1020));
        wr(1, 32'h900);
        wr(0, 32'h24);
        rd(0, v); chk("R11 busy error and held mode", 64'(v), 64'(CONST | 32'h3020));
        repeat (30) @(negedge clk);
        rd(1, v); chk("R11 dropped addr write", 64'(v), 64'h800);
        chk("R11 one write issued", 64'(wr_count - n0), 64'd1);
        wr(0, 32'h2020);
        rd(0, v); chk("R11 busy error cleared", 64'(v), 64'(CONST | 32'h20));
        lat = 2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_basic();
        t_autoinc_write();
        t_carry();
        t_read_on_addr();
        t_read_on_data();
        t_64bit();
        t_size_err();
        t_fault();
        t_busy();
        if (!done) begin
            done = 1'b1;
            report();
        end
    end

endmodule